// File: doc/BRIEF.md
# SPI transaction engine with chip-select hold

This block is a serial peripheral master that carries one complete memory transaction inside a single chip-select envelope. The host picks a length of one, two or four bytes, places the bytes left-aligned in a 32-bit transmit word and pulses `start`. The engine then pulls chip select low and clocks every byte out most significant bit first in mode 0, collecting the bytes that come back. It raises chip select only after the final bit. A single-byte write-enable command (0x06), a status write (0x01 then 0x00) and a four-byte access (command, address high byte, address low byte, data) each fit in one call.

Once chip select has been released, the engine holds it high for a minimum deselect interval. The interval is given in nanoseconds and converted to clock cycles from the clock-frequency parameter. Only after it has elapsed does the engine accept another request. `busy` covers both the shifting and this interval, so the host only has to wait for `busy` to fall. The received bits are returned right-aligned, which places the byte from the last slot in the low eight bits. A one-cycle `done` strobe marks their arrival.

Top module: `spi_txn_engine`

## Requirements
- R1: While `rst_n` is low, asynchronously and without a clock edge, `cs_n` is 1, `sclk` is 0, `busy` is 0 and `done` is 0.
- R2: `len_sel` selects the length: 2'b00 gives 1 byte, 2'b01 gives 2 bytes, and 2'b10 or 2'b11 give 4 bytes. `cs_n` falls once per transaction and stays low until exactly 8 times that many rising `sclk` edges have occurred.
- R3: Bits go out on `mosi` MSB first, starting at `tx_word[31]` and continuing downwards through the selected number of bytes. `mosi` changes only when `sclk` falls or while `sclk` is low, never at or during an `sclk` high phase.
- R4: `miso` is sampled on each rising `sclk` edge. `rx_word` holds the sampled bits right-aligned, with the first bit received most significant and unused upper bits zero, so the final byte slot lands in `rx_word[7:0]`.
- R5: `done` is high for exactly one cycle, and that is the cycle in which `cs_n` has just returned high. `rx_word` is valid from that cycle on.
- R6: After `cs_n` rises it stays high for at least ceil(GAP_NS * CLK_HZ / 1e9) clock cycles before it can fall again.
- R7: `busy` is 1 in the cycle after an accepted `start` and stays 1 until the deselect interval has elapsed. `cs_n` is never low while `busy` is 0.
- R8: A `start` pulse while `busy` is 1 is ignored. The running transfer keeps its own data and length, and no further transaction follows.
- R9: `sclk` is 0 whenever `cs_n` is 1. Each `sclk` level lasts SCLK_HALF clock cycles, so consecutive rising edges are 2*SCLK_HALF cycles apart.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Request pulse, accepted only while idle |
| len_sel | input | 2 | Transaction length code (R2) |
| tx_word | input | 32 | Bytes to send, first byte in bits 31:24 |
| rx_word | output | 32 | Received bits, right-aligned |
| busy | output | 1 | Transfer or deselect interval in progress |
| done | output | 1 | One-cycle end-of-transaction strobe |
| sclk | output | 1 | Serial clock, idles low |
| mosi | output | 1 | Serial data out |
| miso | input | 1 | Serial data in |
| cs_n | output | 1 | Active-low chip select |

## Verification
The bench uses CLK_HZ = 100 MHz, SCLK_HALF = 2 and GAP_NS = 350. These values give a 35-cycle minimum deselect interval, which can be measured exactly between two back-to-back requests. A short serial half-period keeps a full 32-bit transfer to about 130 cycles, so every length code, a mid-transfer `start`, and an asynchronous reset in the middle of a transfer all fit in a short run. The other end of the link is modelled in the bench, which shifts a known pattern onto `miso` and records `mosi` on each rising edge.

// File: rtl/spi_txn_pkg.sv
package spi_txn_pkg;

  localparam int TXN_MAX_BYTES = 4;
  localparam int TXN_W         = 8 * TXN_MAX_BYTES;
  localparam int TXN_BW        = $clog2(TXN_W + 1);

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_XFER = 2'd1,
    ST_GAP  = 2'd2
  } txn_state_t;

  // Minimum deselect time rounded up to whole clock cycles, never below one.
  function automatic int unsigned gap_cycles(input longint unsigned clk_hz,
                                             input longint unsigned gap_ns);
    longint unsigned prod;
    longint unsigned cyc;
    prod = clk_hz * gap_ns + 64'd999_999_999;
    cyc  = prod / 64'd1_000_000_000;
    if (cyc == 64'd0) return 1;
    return 32'(cyc);
  endfunction

  // Length code to bit count: 00 -> 8, 01 -> 16, 1x -> 32.
  function automatic logic [TXN_BW-1:0] bits_for_len(input logic [1:0] sel);
    case (sel)
      2'b00:   return TXN_BW'(8);
      2'b01:   return TXN_BW'(16);
      default: return TXN_BW'(TXN_W);
    endcase
  endfunction

endpackage

// File: rtl/spi_sclk_div.sv
module spi_sclk_div #(
  parameter int HALF = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  output logic tick
);
  localparam int CW = (HALF > 1) ? $clog2(HALF) : 1;

  logic [CW-1:0] cnt;

  assign tick = run && (cnt == CW'(HALF - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     cnt <= '0;
    else if (!run)  cnt <= '0;
    else if (tick)  cnt <= '0;
    else            cnt <= cnt + CW'(1);
  end
endmodule

// File: rtl/spi_gap_timer.sv
module spi_gap_timer #(
  parameter int unsigned GAP_CYC = 35
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  output logic expired
);
  localparam int GW = (GAP_CYC > 1) ? $clog2(GAP_CYC + 1) : 1;

  logic [GW-1:0] cnt;

  assign expired = run && (cnt == GW'(GAP_CYC - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        cnt <= '0;
    else if (!run)     cnt <= '0;
    else if (!expired) cnt <= cnt + GW'(1);
  end
endmodule

// File: rtl/spi_shift_unit.sv
module spi_shift_unit
  import spi_txn_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [1:0]        len_sel,
  input  logic [TXN_W-1:0]  tx_word,
  input  logic              rise,
  input  logic              fall,
  input  logic              miso,
  output logic              mosi,
  output logic [TXN_W-1:0]  rx_bits,
  output logic              last_bit
);
  logic [TXN_W-1:0]  tx_sh;
  logic [TXN_BW-1:0] nbits;
  logic [TXN_BW-1:0] idx;

  assign mosi     = tx_sh[TXN_W-1];
  assign last_bit = (idx == nbits - TXN_BW'(1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tx_sh   <= '0;
      rx_bits <= '0;
      nbits   <= TXN_BW'(8);
      idx     <= '0;
    end else if (load) begin
      tx_sh   <= tx_word;
      rx_bits <= '0;
      nbits   <= bits_for_len(len_sel);
      idx     <= '0;
    end else begin
      if (rise) rx_bits <= {rx_bits[TXN_W-2:0], miso};
      if (fall) begin
        tx_sh <= {tx_sh[TXN_W-2:0], 1'b0};
        idx   <= idx + TXN_BW'(1);
      end
    end
  end
endmodule

// File: rtl/spi_txn_engine.sv
module spi_txn_engine
  import spi_txn_pkg::*;
#(
  parameter int CLK_HZ    = 100_000_000,
  parameter int SCLK_HALF = 2,
  parameter int GAP_NS    = 350
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        start,
  input  logic [1:0]  len_sel,
  input  logic [31:0] tx_word,
  output logic [31:0] rx_word,
  output logic        busy,
  output logic        done,
  output logic        sclk,
  output logic        mosi,
  input  logic        miso,
  output logic        cs_n
);
  localparam int unsigned GAP_CYC = gap_cycles(CLK_HZ, GAP_NS);

  txn_state_t st;

  logic evt_tick;
  logic evt_accept;
  logic evt_rise;
  logic evt_fall;
  logic evt_end;
  logic gap_end;
  logic last_bit;
  logic [TXN_W-1:0] rx_bits;
  logic [31:0] gap_len_w;

  assign gap_len_w  = GAP_CYC;
  assign evt_accept = (st == ST_IDLE) && start;
  assign evt_rise   = (st == ST_XFER) && evt_tick && !sclk;
  assign evt_fall   = (st == ST_XFER) && evt_tick && sclk;
  assign evt_end    = evt_fall && last_bit;
  assign busy       = (st != ST_IDLE);

  spi_sclk_div #(.HALF(SCLK_HALF)) u_div (
    .clk   (clk),
    .rst_n (rst_n),
    .run   (st == ST_XFER),
    .tick  (evt_tick)
  );

  spi_shift_unit u_shift (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (evt_accept),
    .len_sel  (len_sel),
    .tx_word  (tx_word),
    .rise     (evt_rise),
    .fall     (evt_fall),
    .miso     (miso),
    .mosi     (mosi),
    .rx_bits  (rx_bits),
    .last_bit (last_bit)
  );

  spi_gap_timer #(.GAP_CYC(GAP_CYC)) u_gap (
    .clk     (clk),
    .rst_n   (rst_n),
    .run     (st == ST_GAP),
    .expired (gap_end)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st      <= ST_IDLE;
      cs_n    <= 1'b1;
      sclk    <= 1'b0;
      done    <= 1'b0;
      rx_word <= '0;
    end else begin
      done <= evt_end;
      case (st)
        ST_IDLE: if (evt_accept) begin
          cs_n <= 1'b0;
          st   <= ST_XFER;
        end
        ST_XFER: begin
          if (evt_rise) sclk <= 1'b1;
          if (evt_fall) sclk <= 1'b0;
          if (evt_end) begin
            cs_n    <= 1'b1;
            rx_word <= rx_bits;
            st      <= ST_GAP;
          end
        end
        ST_GAP:  if (gap_end) st <= ST_IDLE;
        default: st <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/spi_txn_checker.sv
module spi_txn_checker (
  input logic        clk,
  input logic        rst_n,
  input logic        start,
  input logic        busy,
  input logic        done,
  input logic        cs_n,
  input logic        sclk,
  input logic        mosi,
  input logic [31:0] gap_len
);
  logic [31:0] hi_cnt;
  logic        seen_end;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hi_cnt   <= '0;
      seen_end <= 1'b0;
    end else begin
      if (done) seen_end <= 1'b1;
      if (!cs_n)                hi_cnt <= '0;
      else if (hi_cnt != '1)    hi_cnt <= hi_cnt + 32'd1;
    end
  end

  AST_SCLK_IDLE_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    cs_n |-> !sclk); // R9

  AST_DONE_AT_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cs_n) |-> done); // R5

  AST_DONE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done); // R5

  AST_BUSY_AFTER_START: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !busy) |=> busy); // R7

  AST_CS_ONLY_WHEN_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    !cs_n |-> busy); // R7

  AST_MOSI_HELD_AT_RISE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sclk) |-> $stable(mosi)); // R3

  AST_MOSI_HELD_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    (sclk && $past(sclk)) |-> $stable(mosi)); // R3

  AST_MIN_DESELECT: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(cs_n) && seen_end) |-> (hi_cnt >= gap_len)); // R6
endmodule

bind spi_txn_engine spi_txn_checker u_chk (
  .clk     (clk),
  .rst_n   (rst_n),
  .start   (start),
  .busy    (busy),
  .done    (done),
  .cs_n    (cs_n),
  .sclk    (sclk),
  .mosi    (mosi),
  .gap_len (gap_len_w)
);

// File: tb/tb_spi_txn_engine.sv
`timescale 1ns/1ps
module tb_spi_txn_engine;
  localparam int HALF    = 2;
  localparam int GAP_MIN = 35; // ceil(350 ns * 100 MHz)

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [1:0]  len_sel = 2'b00;
  logic [31:0] tx_word = '0;
  logic [31:0] rx_word;
  logic        busy, done, sclk, mosi, cs_n;
  logic        miso = 1'b0;

  int checks = 0;
  int fails  = 0;

  spi_txn_engine #(.CLK_HZ(100_000_000), .SCLK_HALF(HALF), .GAP_NS(350)) dut (
    .clk(clk), .rst_n(rst_n), .start(start), .len_sel(len_sel),
    .tx_word(tx_word), .rx_word(rx_word), .busy(busy), .done(done),
    .sclk(sclk), .mosi(mosi), .miso(miso), .cs_n(cs_n)
  );

  always #5 clk = ~clk;

  // Link partner model and monitors
  logic [31:0] slave_word = '0;
  logic [31:0] mosi_cap = '0;
  int sl_idx = 0;
  int rises = 0;
  int cs_bad = 0;
  int per_bad = 0;
  int cs_rises = 0;
  int cyc = 0;
  int last_rise_cyc = -1;
  int hi_run = 0;
  int last_gap = 0;

  always @(posedge clk) cyc = cyc + 1;

  always @(negedge cs_n) begin
    sl_idx = 0;
    miso = slave_word[31];
  end

  always @(negedge sclk) if (!cs_n) begin
    sl_idx = sl_idx + 1;
    if (sl_idx < 32) miso = slave_word[31 - sl_idx];
  end

  always @(posedge sclk) begin
    if (cs_n) cs_bad = cs_bad + 1;
    else begin
      mosi_cap = {mosi_cap[30:0], mosi};
      rises = rises + 1;
      if (last_rise_cyc >= 0 && (cyc - last_rise_cyc) != 2 * HALF) per_bad = per_bad + 1;
      last_rise_cyc = cyc;
    end
  end

  always @(posedge cs_n) cs_rises = cs_rises + 1;

  always @(negedge clk) begin
    if (cs_n) hi_run = hi_run + 1;
    else begin
      if (hi_run != 0) last_gap = hi_run;
      hi_run = 0;
    end
  end

  task automatic check(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  function automatic int nbytes(input logic [1:0] sel);
    return (sel == 2'b00) ? 1 : (sel == 2'b01) ? 2 : 4;
  endfunction

  task automatic clear_mon();
    mosi_cap = '0; rises = 0; cs_bad = 0; per_bad = 0; cs_rises = 0; last_rise_cyc = -1;
  endtask

  task automatic wait_idle();
    int n = 0;
    while (busy && n < 5000) begin @(negedge clk); n++; end
  endtask

  task automatic wait_done(output bit seen);
    int n = 0;
    seen = 0;
    while (!seen && n < 5000) begin
      @(negedge clk); n++;
      if (done) seen = 1;
    end
  endtask

  // Issue one transaction and verify it completely.
  task automatic run_txn(input logic [1:0] sel, input logic [31:0] tx,
                         input logic [31:0] sw, input string tag);
    int nb = nbytes(sel);
    int sh = 32 - 8 * nb;
    bit seen;
    wait_idle();
    @(negedge clk);
    clear_mon();
    slave_word = sw; tx_word = tx; len_sel = sel; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    check(busy === 1'b1, "R7", {tag, " busy after start"}, 32'(busy), 32'd1);
    check(cs_n === 1'b0, "R2", {tag, " cs low after start"}, 32'(cs_n), 32'd0);
    wait_done(seen);
    check(seen, "R5", {tag, " done seen"}, 32'(seen), 32'd1);
    check(cs_n === 1'b1, "R5", {tag, " cs high with done"}, 32'(cs_n), 32'd1);
    check(rises == 8 * nb, "R2", {tag, " sclk rises"}, 32'(rises), 32'(8 * nb));
    check(cs_rises == 1 && cs_bad == 0, "R2", {tag, " single envelope"}, 32'(cs_rises), 32'd1);
    check(mosi_cap == (tx >> sh), "R3", {tag, " mosi bits"}, mosi_cap, tx >> sh);
    check(rx_word == (sw >> sh), "R4", {tag, " rx_word"}, rx_word, sw >> sh);
    check(per_bad == 0, "R9", {tag, " sclk period"}, 32'(per_bad), 32'd0);
    @(negedge clk);
    check(done === 1'b0, "R5", {tag, " done one cycle"}, 32'(done), 32'd0);
    check(busy === 1'b1, "R7", {tag, " busy during gap"}, 32'(busy), 32'd1);
    wait_idle();
    check(cs_n === 1'b1 && sclk === 1'b0, "R9", {tag, " idle levels"},
          {30'd0, cs_n, sclk}, 32'd2);
  endtask

  task automatic t_reset();
    check(cs_n === 1'b1, "R1", "reset cs_n", 32'(cs_n), 32'd1);
    check(sclk === 1'b0, "R1", "reset sclk", 32'(sclk), 32'd0);
    check(busy === 1'b0, "R1", "reset busy", 32'(busy), 32'd0);
    check(done === 1'b0, "R1", "reset done", 32'(done), 32'd0);
  endtask

  task automatic t_lengths();
    run_txn(2'b00, 32'h0600_0000, 32'hA500_0000, "wren");
    run_txn(2'b01, 32'h0100_0000, 32'h3CC3_0000, "wrsr");
    run_txn(2'b10, 32'h0312_34FF, 32'h0000_005A, "read4");
    run_txn(2'b11, 32'h02AB_CD81, 32'hF0E1_D2C3, "write4");
  endtask

  task automatic t_gap();
    bit seen;
    run_txn(2'b00, 32'h0600_0000, 32'h0, "gapA");
    // Request immediately as busy drops; gap measured on cs_n.
    @(negedge clk);
    tx_word = 32'h0100_0000; len_sel = 2'b01; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    check(last_gap >= GAP_MIN, "R6", "deselect cycles", 32'(last_gap), 32'(GAP_MIN));
    wait_done(seen);
    wait_idle();
  endtask

  task automatic t_ignore();
    bit seen;
    wait_idle();
    @(negedge clk);
    clear_mon();
    slave_word = 32'h1234_5678; tx_word = 32'hC3A5_0F96; len_sel = 2'b10; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    repeat (20) @(negedge clk);
    tx_word = 32'hFFFF_FFFF; len_sel = 2'b00; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    wait_done(seen);
    check(mosi_cap == 32'hC3A5_0F96, "R8", "data kept", mosi_cap, 32'hC3A5_0F96);
    check(rises == 32, "R8", "length kept", 32'(rises), 32'd32);
    wait_idle();
    repeat (6) @(negedge clk);
    check(cs_n === 1'b1 && cs_rises == 1, "R8", "no extra txn", 32'(cs_rises), 32'd1);
  endtask

  task automatic t_async_reset();
    wait_idle();
    @(negedge clk);
    tx_word = 32'h0300_0010; len_sel = 2'b10; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    repeat (30) @(negedge clk);
    rst_n = 1'b0;
    #1;
    check(cs_n === 1'b1 && sclk === 1'b0 && busy === 1'b0, "R1", "async reset mid transfer",
          {29'd0, cs_n, sclk, busy}, 32'd4);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    run_txn(2'b01, 32'h0500_0000, 32'h8001_0000, "after_reset");
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    t_lengths();
    t_gap();
    t_ignore();
    t_async_reset();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog run did not finish actual=%0d expected=0", 1);
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule